// File: doc/BRIEF.md
# Vector element enable and prefill generator

This block sorts the elements of one vector register group into classes and builds the two things a vector execution lane needs before any element arithmetic starts. The first is a per-element write-enable vector. The second is a result vector in which every slot that will not be written already holds the old destination value. The element classes, in priority order, are: before the start index, past the vector length, past the usable count of a fractional group, masked off, and active.

A two-bit mode selects how the enables and the prefilled result are built. Arithmetic mode uses full-width element slots. Source mode is for stores and reductions; it produces enables only and no destination. Carry mode builds a packed bit-per-element result and does not look at the mask. Compare mode builds a packed bit-per-element result and honours the mask.

A start index beyond the largest element index that the current element width allows is reserved. In that case the block raises an error and suppresses all enables. The output stage is registered by default; a parameter turns it into a purely combinational path.

Top module: `vmask_gen`

## Requirements
- R1: An element whose index is below `vstart_i` has enable 0, and its result slot holds the old value.
- R2: An element whose index is greater than or equal to `vl_i` has enable 0, and its result slot holds the old value. With `vl_i` = 0, no element is enabled.
- R3: The usable count is `num_elem_i` when `lmul_pow_i` (3-bit two's complement) is zero or positive, and `num_elem_i >> -lmul_pow_i` when it is negative. Elements at or beyond the usable count have enable 0 and keep the old value.
- R4: In modes 0 (arithmetic), 1 (source) and 3 (compare), an element whose `vmask_i` bit is 0 has enable 0 and keeps the old value.
- R5: Every element not excluded by R1 to R4 has enable 1, and its result slot is zero.
- R6: In mode 2 (carry), `vmask_i` has no effect on either output.
- R7: In mode 0, element i occupies `res_o[i*ELEM_W +: ELEM_W]`, and a disabled element copies `old_i` at the same position.
- R8: In modes 2 and 3, bit i of `res_o` is `old_i[i]` for a disabled element and 0 for an active one. All bits of `res_o` at or above MAX_ELEM are 0.
- R9: In mode 1, `res_o` is all zero.
- R10: `sew_pow_i` gives the element width as 2^sew_pow_i and is legal only in the range 3 to 6. When it is outside that range, or when `vstart_i` exceeds 2^(3+VLEN_POW-sew_pow_i)-1, `err_o` is 1 and both `wen_o` and `res_o` are zero. Otherwise `err_o` is 0.
- R11: With OUT_REG=1, the outputs follow the inputs one clock later. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock for the optional output stage |
| rst_ni | input | 1 | asynchronous reset, active low |
| num_elem_i | input | CNT_W | element count of the register group |
| vstart_i | input | VS_W | first element index to process |
| vl_i | input | VS_W | vector length |
| lmul_pow_i | input | 3 | signed group multiplier exponent |
| sew_pow_i | input | 3 | log2 of element width in bits |
| mode_i | input | 2 | 0 arithmetic, 1 source, 2 carry, 3 compare |
| vmask_i | input | MAX_ELEM | per-element mask bits |
| old_i | input | MAX_ELEM*ELEM_W | old destination contents |
| wen_o | output | MAX_ELEM | per-element write enable |
| res_o | output | MAX_ELEM*ELEM_W | prefilled result |
| err_o | output | 1 | reserved start index or element width |

## Verification
A wrong class for one element shows up in the very next registered output. Either a stray or missing `wen_o` bit appears, or the matching `res_o` slot holds zero where the old value belongs, or the reverse. The directed cases put the start index, the vector length and the fractional-group limit on single-element boundaries, so an off-by-one in any comparison changes exactly one enable bit. A wrong reserved-range limit shows as `err_o` toggling one index early or late, and the enables collapse to zero in the same cycle. A swapped mode decode alters the layout of `res_o` at once: slot width, packed bits, or all zero.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
  typedef enum logic [1:0] {
    MODE_ARITH = 2'd0,
    MODE_SRC   = 2'd1,
    MODE_CARRY = 2'd2,
    MODE_CMP   = 2'd3
  } vmask_mode_e;

  typedef enum logic [2:0] {
    CLS_PRE    = 3'd0,
    CLS_VLTAIL = 3'd1,
    CLS_FRTAIL = 3'd2,
    CLS_INACT  = 3'd3,
    CLS_ACT    = 3'd4
  } elem_cls_e;
endpackage

// File: rtl/vmask_span.sv
module vmask_span #(
  parameter int unsigned CNT_W = 7,
  parameter int unsigned VS_W  = 16
) (
  input  logic [CNT_W-1:0]  num_elem_i,
  input  logic signed [2:0] lmul_pow_i,
  output logic [VS_W-1:0]   usable_o
);
  logic [2:0]       neg_sh;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    neg_sh = 3'd0;
    if (lmul_pow_i[2]) neg_sh = 3'(-lmul_pow_i);
    cnt      = num_elem_i >> neg_sh;
    usable_o = VS_W'(cnt);
  end
endmodule

// File: rtl/vmask_vstart_chk.sv
module vmask_vstart_chk #(
  parameter int unsigned VS_W     = 16,
  parameter int unsigned VLEN_POW = 9
) (
  input  logic [VS_W-1:0] vstart_i,
  input  logic [2:0]      sew_pow_i,
  output logic            err_o
);
  localparam int unsigned SH_TOP = 3 + VLEN_POW;

  logic [5:0]      sh;
  logic [VS_W-1:0] over;
  logic            sew_bad;

  always_comb begin
    sew_bad = (sew_pow_i < 3'd3) || (sew_pow_i > 3'd6);
    sh      = 6'(SH_TOP) - {3'b000, sew_pow_i};
    over    = vstart_i >> sh;
    err_o   = sew_bad || (over != '0);
  end
endmodule

// File: rtl/vmask_elem_cls.sv
module vmask_elem_cls
  import vmask_pkg::*;
#(
  parameter int unsigned IDX  = 0,
  parameter int unsigned VS_W = 16
) (
  input  logic [VS_W-1:0] vstart_i,
  input  logic [VS_W-1:0] vl_i,
  input  logic [VS_W-1:0] usable_i,
  input  logic            mask_bit_i,
  input  logic            use_mask_i,
  output elem_cls_e       cls_o
);
  localparam logic [VS_W-1:0] IDX_V = VS_W'(IDX);

  // fixed priority: prestart > vl tail > fractional tail > inactive
  always_comb begin
    if (IDX_V < vstart_i)                cls_o = CLS_PRE;
    else if (IDX_V >= vl_i)              cls_o = CLS_VLTAIL;
    else if (IDX_V >= usable_i)          cls_o = CLS_FRTAIL;
    else if (use_mask_i && !mask_bit_i)  cls_o = CLS_INACT;
    else                                 cls_o = CLS_ACT;
  end
endmodule

// File: rtl/vmask_gen.sv
module vmask_gen
  import vmask_pkg::*;
#(
  parameter int unsigned MAX_ELEM = 64,
  parameter int unsigned ELEM_W   = 8,
  parameter int unsigned VS_W     = 16,
  parameter int unsigned VLEN_POW = 9,
  parameter bit          OUT_REG  = 1'b1,
  parameter int unsigned CNT_W    = $clog2(MAX_ELEM + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [CNT_W-1:0]           num_elem_i,
  input  logic [VS_W-1:0]            vstart_i,
  input  logic [VS_W-1:0]            vl_i,
  input  logic signed [2:0]          lmul_pow_i,
  input  logic [2:0]                 sew_pow_i,
  input  logic [1:0]                 mode_i,
  input  logic [MAX_ELEM-1:0]        vmask_i,
  input  logic [MAX_ELEM*ELEM_W-1:0] old_i,
  output logic [MAX_ELEM-1:0]        wen_o,
  output logic [MAX_ELEM*ELEM_W-1:0] res_o,
  output logic                       err_o
);
  localparam int unsigned RES_W = MAX_ELEM * ELEM_W;

  vmask_mode_e     mode;
  logic [VS_W-1:0] usable;
  logic            err_d;
  logic            use_mask;
  elem_cls_e       cls [MAX_ELEM];

  logic [MAX_ELEM-1:0] wen_raw;
  logic [RES_W-1:0]    slot_res;
  logic [MAX_ELEM-1:0] bit_res;

  logic [MAX_ELEM-1:0] wen_d;
  logic [RES_W-1:0]    res_d;

  assign mode     = vmask_mode_e'(mode_i);
  assign use_mask = (mode != MODE_CARRY);

  vmask_span #(.CNT_W(CNT_W), .VS_W(VS_W)) u_span (
    .num_elem_i (num_elem_i),
    .lmul_pow_i (lmul_pow_i),
    .usable_o   (usable)
  );

  vmask_vstart_chk #(.VS_W(VS_W), .VLEN_POW(VLEN_POW)) u_vchk (
    .vstart_i  (vstart_i),
    .sew_pow_i (sew_pow_i),
    .err_o     (err_d)
  );

  for (genvar i = 0; i < MAX_ELEM; i++) begin : g_elem
    vmask_elem_cls #(.IDX(i), .VS_W(VS_W)) u_cls (
      .vstart_i   (vstart_i),
      .vl_i       (vl_i),
      .usable_i   (usable),
      .mask_bit_i (vmask_i[i]),
      .use_mask_i (use_mask),
      .cls_o      (cls[i])
    );

    always_comb begin
      wen_raw[i] = (cls[i] == CLS_ACT);
      slot_res[i*ELEM_W +: ELEM_W] = wen_raw[i] ? '0 : old_i[i*ELEM_W +: ELEM_W];
      bit_res[i] = wen_raw[i] ? 1'b0 : old_i[i];
    end
  end

  always_comb begin
    wen_d = '0;
    res_d = '0;
    if (!err_d) begin
      wen_d = wen_raw;
      unique case (mode)
        MODE_ARITH:          res_d = slot_res;
        MODE_CARRY, MODE_CMP: res_d = RES_W'(bit_res);
        default:             res_d = '0;
      endcase
    end
  end

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wen_o <= '0;
        res_o <= '0;
        err_o <= 1'b0;
      end else begin
        wen_o <= wen_d;
        res_o <= res_d;
        err_o <= err_d;
      end
    end
  end else begin : g_comb
    assign wen_o = wen_d;
    assign res_o = res_d;
    assign err_o = err_d;
  end
endmodule

// File: rtl/vmask_gen_chk.sv
module vmask_gen_chk
  import vmask_pkg::*;
#(
  parameter int unsigned MAX_ELEM = 64,
  parameter int unsigned ELEM_W   = 8,
  parameter int unsigned VS_W     = 16,
  parameter int unsigned VLEN_POW = 9,
  parameter bit          OUT_REG  = 1'b1,
  parameter int unsigned CNT_W    = $clog2(MAX_ELEM + 1)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [CNT_W-1:0]           num_elem_i,
  input logic [VS_W-1:0]            vstart_i,
  input logic [VS_W-1:0]            vl_i,
  input logic signed [2:0]          lmul_pow_i,
  input logic [2:0]                 sew_pow_i,
  input logic [1:0]                 mode_i,
  input logic [MAX_ELEM-1:0]        vmask_i,
  input logic [MAX_ELEM*ELEM_W-1:0] old_i,
  input logic [MAX_ELEM-1:0]        wen_o,
  input logic [MAX_ELEM*ELEM_W-1:0] res_o,
  input logic                       err_o
);
  logic [VS_W-1:0]            d_vstart;
  logic [VS_W-1:0]            d_vl;
  logic [1:0]                 d_mode;
  logic [MAX_ELEM-1:0]        d_vm;
  logic [MAX_ELEM*ELEM_W-1:0] d_old;
  logic                       chk_ok;

  if (OUT_REG) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        d_vstart <= '0;
        d_vl     <= '0;
        d_mode   <= '0;
        d_vm     <= '0;
        d_old    <= '0;
        chk_ok   <= 1'b0;
      end else begin
        d_vstart <= vstart_i;
        d_vl     <= vl_i;
        d_mode   <= mode_i;
        d_vm     <= vmask_i;
        d_old    <= old_i;
        chk_ok   <= 1'b1;
      end
    end
  end else begin : g_nodly
    always_comb begin
      d_vstart = vstart_i;
      d_vl     = vl_i;
      d_mode   = mode_i;
      d_vm     = vmask_i;
      d_old    = old_i;
      chk_ok   = 1'b1;
    end
  end

  // R10
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !chk_ok)
    err_o |-> (wen_o == '0 && res_o == '0));

  // R4
  inactive_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !chk_ok)
    (d_mode != 2'd2) |-> ((wen_o & ~d_vm) == '0));

  // R2
  vl_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !chk_ok)
    $countones(wen_o) <= int'(d_vl));

  // R1
  prestart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !chk_ok)
    (d_vstart != '0) |-> !wen_o[0]);

  // R9
  src_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !chk_ok)
    (d_mode == 2'd1) |-> (res_o == '0));

  for (genvar i = 0; i < MAX_ELEM; i++) begin : g_slot
    // R7
    keep_old_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || !chk_ok)
      (d_mode == 2'd0 && !err_o && !wen_o[i]) |->
        (res_o[i*ELEM_W +: ELEM_W] == d_old[i*ELEM_W +: ELEM_W]));
  end
endmodule

bind vmask_gen vmask_gen_chk #(
  .MAX_ELEM (MAX_ELEM),
  .ELEM_W   (ELEM_W),
  .VS_W     (VS_W),
  .VLEN_POW (VLEN_POW),
  .OUT_REG  (OUT_REG),
  .CNT_W    (CNT_W)
) u_chk (.*);

// File: tb/sim_vmask_gen.sv
module sim_vmask_gen;
  localparam int unsigned ME    = 64;
  localparam int unsigned EW    = 8;
  localparam int unsigned VSW   = 16;
  localparam int unsigned VLP   = 9;
  localparam int unsigned CW    = $clog2(ME + 1);
  localparam int unsigned RW    = ME * EW;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [CW-1:0]        num_elem = '0;
  logic [VSW-1:0]       vstart = '0;
  logic [VSW-1:0]       vl = '0;
  logic signed [2:0]    lmul = '0;
  logic [2:0]           sew = 3'd3;
  logic [1:0]           mode = '0;
  logic [ME-1:0]        vm = '0;
  logic [RW-1:0]        old = '0;
  logic [ME-1:0]        wen;
  logic [RW-1:0]        res;
  logic                 err;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vmask_gen #(.MAX_ELEM(ME), .ELEM_W(EW), .VS_W(VSW), .VLEN_POW(VLP), .OUT_REG(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .num_elem_i(num_elem), .vstart_i(vstart), .vl_i(vl),
    .lmul_pow_i(lmul), .sew_pow_i(sew), .mode_i(mode), .vmask_i(vm), .old_i(old),
    .wen_o(wen), .res_o(res), .err_o(err)
  );

  logic [ME-1:0] e_wen;
  logic [RW-1:0] e_res;
  logic          e_err;

  task automatic model();
    int usable;
    int lim_sh;
    bit act;
    usable = (lmul < 0) ? (int'(num_elem) >> (-int'(lmul))) : int'(num_elem);
    e_err  = (sew < 3) || (sew > 6);
    if (!e_err) begin
      lim_sh = 3 + VLP - int'(sew);
      e_err  = (lim_sh < VSW) && ((int'(vstart) >> lim_sh) != 0);
    end
    e_wen = '0;
    e_res = '0;
    for (int i = 0; i < ME; i++) begin
      act = (i >= int'(vstart)) && (i < int'(vl)) && (i < usable) && (mode == 2'd2 || vm[i]);
      e_wen[i] = act;
      if (mode == 2'd0 && !act) e_res[i*EW +: EW] = old[i*EW +: EW];
      if ((mode == 2'd2 || mode == 2'd3) && !act) e_res[i] = old[i];
    end
    if (e_err) begin
      e_wen = '0;
      e_res = '0;
    end
  endtask

  task automatic chk(input string req, input string what, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at negedge, output registered at next posedge, sample at following negedge
  task automatic apply(input string req);
    model();
    @(posedge clk);
    @(negedge clk);
    chk(req, "wen", RW'(wen), RW'(e_wen));
    chk(req, "res", res, e_res);
    chk(req, "err", RW'(err), RW'(e_err));
  endtask

  task automatic set_case(input int n, input int vs, input int l, input int lm, input int sw, input int md);
    num_elem = CW'(n);
    vstart   = VSW'(vs);
    vl       = VSW'(l);
    lmul     = 3'(lm);
    sew      = 3'(sw);
    mode     = 2'(md);
  endtask

  task automatic fill_old(input int seed);
    for (int i = 0; i < ME; i++) old[i*EW +: EW] = 8'(i * 7 + seed);
  endtask

  task automatic t_reset();
    chk("R11", "reset wen", RW'(wen), '0);
    chk("R11", "reset res", res, '0);
    chk("R11", "reset err", RW'(err), '0);
  endtask

  task automatic t_all_active();
    fill_old(3);
    vm = '1;
    set_case(64, 0, 64, 0, 3, 0);
    apply("R5");
    chk("R5", "all enabled", RW'(wen), RW'({ME{1'b1}}));
    chk("R5", "active slots zero", res, '0);
  endtask

  task automatic t_pre_tail();
    fill_old(11);
    vm = '1;
    set_case(64, 5, 20, 0, 3, 0);
    apply("R1");
    chk("R2", "window 5..19", RW'(wen), RW'(64'h00000000000FFFE0));
    chk("R7", "slot 4 old", RW'(res[4*EW +: EW]), RW'(old[4*EW +: EW]));
    chk("R7", "slot 20 old", RW'(res[20*EW +: EW]), RW'(old[20*EW +: EW]));
  endtask

  task automatic t_inactive();
    fill_old(29);
    vm = 64'hAAAA_5555_F0F0_0F0F;
    set_case(64, 0, 64, 0, 4, 0);
    apply("R4");
    chk("R4", "wen equals mask", RW'(wen), RW'(vm));
  endtask

  task automatic t_frac();
    fill_old(41);
    vm = '1;
    set_case(64, 0, 40, -2, 3, 0);
    apply("R3");
    chk("R3", "16 usable", RW'(wen), RW'(64'h000000000000FFFF));
    set_case(64, 0, 64, -3, 3, 0);
    apply("R3");
    set_case(32, 0, 64, 2, 3, 0);
    apply("R3");
    chk("R3", "count 32", RW'(wen), RW'(64'h00000000FFFFFFFF));
  endtask

  task automatic t_carry();
    fill_old(5);
    vm = '0;
    set_case(64, 2, 10, 0, 3, 2);
    apply("R6");
    chk("R6", "mask ignored", RW'(wen), RW'(64'h00000000000003FC));
    vm = '1;
    apply("R6");
    chk("R8", "packed upper zero", RW'(res >> ME), '0);
  endtask

  task automatic t_cmp();
    fill_old(17);
    vm = 64'h0000_0000_0000_00F3;
    set_case(64, 1, 8, 0, 3, 3);
    apply("R8");
    chk("R8", "cmp wen", RW'(wen), RW'(64'h00000000000000F2));
  endtask

  task automatic t_src();
    fill_old(99);
    vm = 64'hFFFF_0000_FFFF_0000;
    set_case(64, 3, 50, 0, 3, 1);
    apply("R9");
    chk("R9", "src res zero", res, '0);
  endtask

  task automatic t_vl_zero();
    vm = '1;
    set_case(64, 0, 0, 0, 3, 0);
    apply("R2");
    chk("R2", "vl zero none", RW'(wen), '0);
  endtask

  task automatic t_reserved();
    fill_old(1);
    vm = '1;
    set_case(64, 63, 64, 0, 6, 0);
    apply("R10");
    chk("R10", "63 legal at sew64", RW'(err), RW'(1'b0));
    set_case(64, 64, 64, 0, 6, 0);
    apply("R10");
    chk("R10", "64 reserved at sew64", RW'(err), RW'(1'b1));
    set_case(64, 511, 64, 0, 3, 0);
    apply("R10");
    set_case(64, 512, 64, 0, 3, 0);
    apply("R10");
    set_case(64, 0, 64, 0, 7, 0);
    apply("R10");
    chk("R10", "bad sew", RW'(err), RW'(1'b1));
  endtask

  task automatic t_latency();
    vm = '1;
    set_case(64, 0, 3, 0, 3, 0);
    @(posedge clk);
    @(negedge clk);
    set_case(64, 0, 9, 0, 3, 0);
    #1;
    chk("R11", "held until edge", RW'(wen), RW'(64'h7));
    @(posedge clk);
    @(negedge clk);
    chk("R11", "next edge", RW'(wen), RW'(64'h1FF));
  endtask

  task automatic t_sweep();
    logic [31:0] lf;
    int ncnt;
    lf = 32'h1BAD_F00D;
    for (int k = 0; k < 300; k++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      vm = {lf, ~lf} ^ {32'h0, lf[15:0], lf[31:16]};
      fill_old(int'(lf[7:0]));
      ncnt = (lf[9:8] == 2'd0) ? 16 : (lf[9:8] == 2'd1) ? 32 : 64;
      set_case(ncnt, int'(lf[14:10]) % 70, int'(lf[22:16]) % 80,
               int'(lf[25:23]) % 7 - 3, 3 + int'(lf[27:26]), int'(lf[29:28]));
      apply("R4");
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_all_active();
    t_pre_tail();
    t_inactive();
    t_frac();
    t_carry();
    t_cmp();
    t_src();
    t_vl_zero();
    t_reserved();
    t_latency();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule